// File: doc/BRIEF.md
# Symbol-Level Multiuser Precoder Datapath

This block turns a stream of per-user QPSK symbol vectors into precoded transmit vectors for a downlink with NT antennas and NU single-antenna users. The host supplies the real-valued pseudo-inverse P of the channel matrix, with 2·NT rows and 2·NU columns, on a flat port that has no handshake. The symbol vectors arrive with the noise level and the target SNR already folded in.

For every vector the block does four things. It first builds B by flipping the sign of each column of P whose symbol component is negative. Because the QPSK inverse-normal blocks are sign-only diagonals, no table and no run-time inversion are needed. It then forms y = −P·s and computes, for each column, a norm and a correlation. A sign test on the correlation picks the approximate support. The non-negative weight is the correlation divided by the norm, and the output is u = B·t − y.

All data is 16-bit signed with 10 fraction bits. The pipeline accepts one vector per clock and returns each result a fixed 9 cycles later. Backpressure on the output freezes the whole pipeline.

Top module: `slp_precoder`

## Requirements
- R1: While reset is high and on the first cycle after it falls, m_tvalid is 0 and s_tready is 1.
- R2: Matrix packing and output packing follow fixed rules.
  - pinv_mat holds P row by row; element (r,n) sits at bits [(NR·NC−1−(r·NC+n))·16 +: 16], where NR = 2·NT and NC = 2·NU.
  - s_tdata holds component j at [(NC−1−j)·16 +: 16], with j = 2i for the real part and j = 2i+1 for the imaginary part of user i.
  - m_tdata holds u[r] at [(NR−1−r)·16 +: 16]. Rows r < NT are real parts and rows r ≥ NT are imaginary parts.
- R3: B[r][n] equals P[r][n] when symbol component n is non-negative (sign bit clear). Otherwise it is −P[r][n], saturated to [−32768, 32767].
- R4: y[r] is the sum over n of P[r][n]·s[n], negated, arithmetically shifted right by 10 (rounding toward −∞) and saturated to 16 bits.
- R5: For each column, c_n = Σ B[r][n]² and d_n = Σ y[r]·B[r][n], both exact. The weight t_n is 0 when d_n < 0 or c_n = 0. Otherwise t_n = min(32767, floor(d_n·1024 / c_n)).
- R6: u[r] is Σ B[r][n]·t_n, arithmetically shifted right by 10, minus y[r], with the difference saturated to 16 bits.
- R7: With m_tready held high, a vector accepted on clock edge k first shows m_tvalid high after edge k+9.
- R8: With m_tready high, s_tready stays high, so a new vector is accepted on every edge. A burst of N back-to-back vectors yields N consecutive valid output cycles.
- R9: While m_tvalid is high and m_tready is low, s_tready is 0, and m_tvalid and m_tdata hold their values into the next cycle.
- R10: Under any pattern of output backpressure, every accepted vector yields exactly one result, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pinv_mat | input | 4·16·NT·NU | Real pseudo-inverse channel matrix, row-major |
| s_tdata | input | 2·16·NU | Scaled symbol vector |
| s_tvalid | input | 1 | Symbol vector valid |
| s_tready | output | 1 | Block can take a vector this cycle |
| m_tdata | output | 2·16·NT | Precoded vector, real parts then imaginary parts |
| m_tvalid | output | 1 | Result valid |
| m_tready | input | 1 | Downstream accepts the result |

## Verification
The properties take three things for granted:
- pinv_mat does not change while any vector is in flight. The pipeline reads the matrix in its second stage, so the stimulus waits for every outstanding result before loading a new matrix.
- The output-hold and input-block properties rely on the downstream side lowering m_tready only between clock edges.
- The credit properties rely on the source never withdrawing a vector before it is taken.

The stimulus drives m_tready and s_tvalid a fixed delay after each edge and holds a presented vector until it has been taken.

// File: rtl/slp_precoder.sv
module slp_precoder #(
  parameter int NT   = 2,
  parameter int NU   = 2,
  parameter int W    = 16,
  parameter int FB   = 10,
  parameter int DSTG = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [4*W*NT*NU-1:0]  pinv_mat,
  input  logic [2*W*NU-1:0]     s_tdata,
  input  logic                  s_tvalid,
  output logic                  s_tready,
  output logic [2*W*NT-1:0]     m_tdata,
  output logic                  m_tvalid,
  input  logic                  m_tready
);
  localparam int NR  = 2*NT;
  localparam int NC  = 2*NU;
  localparam int UW  = NR*W;
  localparam int AW  = 48;
  localparam int DW  = 64;
  localparam int QB  = W - 1;
  localparam int BPS = (QB + DSTG - 1) / DSTG;
  localparam int DS0 = 3;
  localparam int DE  = DS0 + DSTG;
  localparam int LS  = DE + 1;
  localparam logic signed [AW-1:0] SMAX = AW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

  function automatic logic signed [W-1:0] sat(input logic signed [AW-1:0] v);
    if (v > SMAX) return SMAX[W-1:0];
    if (v < SMIN) return SMIN[W-1:0];
    return v[W-1:0];
  endfunction

  function automatic logic [DW+QB-1:0] dstep(input logic [DW-1:0] r, input logic [DW-1:0] dv,
                                             input logic [QB-1:0] q, input int hi);
    logic [DW-1:0] rr;
    logic [QB-1:0] qq;
    rr = r;
    qq = q;
    for (int i = 0; i < BPS; i++) begin
      if (hi - i >= 0) begin
        if (rr >= (dv << (hi - i))) begin
          rr = rr - (dv << (hi - i));
          qq[hi - i] = 1'b1;
        end
      end
    end
    return {rr, qq};
  endfunction

  logic en;
  logic [LS:0] v;
  assign en       = !m_tvalid || m_tready;
  assign s_tready = en;
  assign m_tvalid = v[LS];

  logic signed [W-1:0] pe [NR][NC];
  logic signed [W-1:0] se [NC];
  always_comb begin
    for (int r = 0; r < NR; r++)
      for (int n = 0; n < NC; n++)
        pe[r][n] = pinv_mat[(NR*NC-1-(r*NC+n))*W +: W];
    for (int j = 0; j < NC; j++)
      se[j] = s_tdata[(NC-1-j)*W +: W];
  end

  logic signed [W-1:0]  s0 [NC];
  logic signed [W-1:0]  bq [1:DE][NR][NC];
  logic signed [W-1:0]  yq [1:DE][NR];
  logic signed [AW-1:0] c2 [NC];
  logic signed [AW-1:0] d2 [NC];
  logic [DW-1:0]        rem [DS0:DE][NC];
  logic [DW-1:0]        dv  [DS0:DE][NC];
  logic [QB-1:0]        q   [DS0:DE][NC];
  logic                 zf  [DS0:DE][NC];
  logic                 sf  [DS0:DE][NC];

  logic signed [W-1:0] b_n [NR][NC];
  logic signed [W-1:0] y_n [NR];
  always_comb begin
    for (int r = 0; r < NR; r++) begin
      logic signed [AW-1:0] acc;
      acc = '0;
      for (int n = 0; n < NC; n++) begin
        b_n[r][n] = s0[n][W-1] ? sat(-AW'(pe[r][n])) : pe[r][n];
        acc = acc + AW'(pe[r][n]) * AW'(s0[n]);
      end
      y_n[r] = sat(-acc >>> FB);
    end
  end

  logic signed [AW-1:0] c_n [NC];
  logic signed [AW-1:0] d_n [NC];
  always_comb begin
    for (int n = 0; n < NC; n++) begin
      c_n[n] = '0;
      d_n[n] = '0;
      for (int r = 0; r < NR; r++) begin
        c_n[n] = c_n[n] + AW'(bq[1][r][n]) * AW'(bq[1][r][n]);
        d_n[n] = d_n[n] + AW'(yq[1][r]) * AW'(bq[1][r][n]);
      end
    end
  end

  logic [DW-1:0] num_n [NC];
  logic [DW-1:0] den_n [NC];
  logic          zf_n  [NC];
  logic          sf_n  [NC];
  always_comb begin
    for (int n = 0; n < NC; n++) begin
      den_n[n] = DW'(c2[n]);
      zf_n[n]  = (d2[n] < 0) || (c2[n] == '0);
      num_n[n] = zf_n[n] ? '0 : (DW'(d2[n]) << FB);
      sf_n[n]  = !zf_n[n] && (num_n[n] >= (den_n[n] << QB));
    end
  end

  logic [QB-1:0] t_n [NC];
  logic [UW-1:0] u_n;
  always_comb begin
    for (int n = 0; n < NC; n++)
      t_n[n] = zf[DE][n] ? '0 : (sf[DE][n] ? '1 : q[DE][n]);
    for (int r = 0; r < NR; r++) begin
      logic signed [AW-1:0] acc;
      acc = '0;
      for (int n = 0; n < NC; n++)
        acc = acc + AW'(bq[DE][r][n]) * AW'($signed({1'b0, t_n[n]}));
      u_n[(NR-1-r)*W +: W] = sat((acc >>> FB) - AW'(yq[DE][r]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) v <= '0;
    else if (en) v <= {v[LS-1:0], s_tvalid};
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s0    <= se;
      bq[1] <= b_n;
      yq[1] <= y_n;
      for (int k = 2; k <= DE; k++) begin
        bq[k] <= bq[k-1];
        yq[k] <= yq[k-1];
      end
      c2 <= c_n;
      d2 <= d_n;
      for (int n = 0; n < NC; n++) begin
        rem[DS0][n] <= num_n[n];
        dv[DS0][n]  <= den_n[n];
        q[DS0][n]   <= '0;
        zf[DS0][n]  <= zf_n[n];
        sf[DS0][n]  <= sf_n[n];
        for (int k = DS0 + 1; k <= DE; k++) begin
          {rem[k][n], q[k][n]} <= dstep(rem[k-1][n], dv[k-1][n], q[k-1][n], QB-1-(k-DS0-1)*BPS);
          dv[k][n] <= dv[k-1][n];
          zf[k][n] <= zf[k-1][n];
          sf[k][n] <= sf[k-1][n];
        end
      end
      m_tdata <= u_n;
    end
  end

  logic [7:0] inflight;
  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else inflight <= inflight + 8'(s_tvalid && s_tready) - 8'(m_tvalid && m_tready);
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata)); // R9
  AST_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |-> !s_tready); // R9
  AST_CREDIT: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> inflight != 8'd0); // R10
  AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    inflight <= 8'(LS + 1)); // R8

  for (genvar n = 0; n < NC; n++) begin : g_div_chk
    AST_DIV_REM: assert property (@(posedge clk) disable iff (rst)
      v[DE] && !zf[DE][n] && !sf[DE][n] |-> rem[DE][n] < dv[DE][n]); // R5
  end
endmodule

// File: tb/tb_slp_precoder.sv
module tb_slp_precoder;
  localparam int NT = 2, NU = 2, W = 16;
  localparam int NR = 2*NT, NC = 2*NU, PW = NR*NC*W, SW = NC*W, UW = NR*W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] pinv_mat;
  logic [SW-1:0] s_tdata = '0;
  logic s_tvalid = 1'b0;
  logic s_tready;
  logic [UW-1:0] m_tdata;
  logic m_tvalid;
  logic m_tready = 1'b1;

  int checks = 0, errors = 0;
  logic [UW-1:0] expq[$];
  string tagq[$];
  shortint pm [NR][NC];
  bit bp_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit stalled_prev = 1'b0;
  logic [UW-1:0] held;

  always #5 clk = ~clk;

  always_comb
    for (int r = 0; r < NR; r++)
      for (int n = 0; n < NC; n++)
        pinv_mat[(NR*NC-1-(r*NC+n))*W +: W] = pm[r][n];

  slp_precoder #(.NT(NT), .NU(NU), .W(W)) dut (
    .clk(clk), .rst(rst), .pinv_mat(pinv_mat),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready));

  function automatic longint sat16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic logic [UW-1:0] model(input logic [SW-1:0] sw);
    longint s[NC], b[NR][NC], y[NR], c[NC], d[NC], t[NC];
    longint acc;
    logic [UW-1:0] o;
    for (int j = 0; j < NC; j++) s[j] = longint'($signed(sw[(NC-1-j)*W +: W]));
    for (int r = 0; r < NR; r++) begin
      acc = 0;
      for (int n = 0; n < NC; n++) begin
        b[r][n] = (s[n] < 0) ? sat16(-longint'(pm[r][n])) : longint'(pm[r][n]);
        acc += longint'(pm[r][n]) * s[n];
      end
      y[r] = sat16((-acc) >>> 10);
    end
    for (int n = 0; n < NC; n++) begin
      c[n] = 0; d[n] = 0;
      for (int r = 0; r < NR; r++) begin
        c[n] += b[r][n] * b[r][n];
        d[n] += y[r] * b[r][n];
      end
      if (d[n] < 0 || c[n] == 0) t[n] = 0;
      else t[n] = ((d[n] * 1024) / c[n] > 32767) ? 32767 : (d[n] * 1024) / c[n];
    end
    for (int r = 0; r < NR; r++) begin
      acc = 0;
      for (int n = 0; n < NC; n++) acc += b[r][n] * t[n];
      o[(NR-1-r)*W +: W] = 16'(sat16((acc >>> 10) - y[r]));
    end
    return o;
  endfunction

  function automatic logic [SW-1:0] qpsk(input int pat, input int amp);
    logic [SW-1:0] w;
    for (int j = 0; j < NC; j++) w[(NC-1-j)*W +: W] = pat[j] ? 16'(-amp) : 16'(amp);
    return w;
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic rand_p(input int lim);
    for (int r = 0; r < NR; r++)
      for (int n = 0; n < NC; n++)
        pm[r][n] = shortint'(int'($urandom_range(2*lim)) - lim);
  endtask

  task automatic send(input logic [SW-1:0] w, input string tag, output int tries);
    bit ok;
    tries = 0;
    s_tdata = w;
    s_tvalid = 1'b1;
    do begin
      @(negedge clk); ok = s_tready; tries++;
      @(posedge clk); #1;
    end while (!ok);
    expq.push_back(model(w));
    tagq.push_back(tag);
    s_tvalid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready = bp_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (stalled_prev) begin
        checks++;
        if (m_tvalid !== 1'b1 || m_tdata !== held) begin
          errors++;
          $display("FAIL R9 held output %h valid %b expected %h valid 1", m_tdata, m_tvalid, held);
        end
      end
      stalled_prev = m_tvalid && !m_tready;
      held = m_tdata;
      if (m_tvalid && !m_tready) begin
        checks++;
        if (s_tready !== 1'b0) begin
          errors++;
          $display("FAIL R9 s_tready=%b expected 0 during stall", s_tready);
        end
      end
      if (m_tvalid && m_tready) begin
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result %h expected none", m_tdata);
        end else begin
          logic [UW-1:0] e;
          string tg;
          e = expq.pop_front();
          tg = tagq.pop_front();
          if (m_tdata !== e) begin
            errors++;
            $display("FAIL %s u=%h expected %h", tg, m_tdata, e);
          end
        end
      end
    end
  end

  initial begin
    #(150000 * 10);
    checks++; errors++;
    $display("FAIL R10 watchdog expired: run active, expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tries, cnt, run;
    for (int r = 0; r < NR; r++)
      for (int n = 0; n < NC; n++) pm[r][n] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_tvalid === 1'b0 && s_tready === 1'b1,
        $sformatf("R1 in reset m_tvalid=%b s_tready=%b expected 0 1", m_tvalid, s_tready));
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(m_tvalid === 1'b0 && s_tready === 1'b1,
        $sformatf("R1 after reset m_tvalid=%b s_tready=%b expected 0 1", m_tvalid, s_tready));

    for (int i = 0; i < NR; i++) pm[i][i] = 16'sd1024;
    @(posedge clk); #1;
    send({16'h0400, 16'hFE00, 16'h0100, 16'h0300}, "R2 identity", tries);
    cnt = 0;
    do begin @(posedge clk); #1; cnt++; end while (!m_tvalid && cnt < 30);
    chk(cnt == 9, $sformatf("R7 latency %0d expected 9", cnt));
    chk(m_tdata === {16'h0400, 16'hFE00, 16'h0100, 16'h0300},
        $sformatf("R2 packing u=%h expected %h", m_tdata, {16'h0400, 16'hFE00, 16'h0100, 16'h0300}));
    drain();

    rand_p(2048);
    for (int pat = 0; pat < 16; pat++) send(qpsk(pat, 300 + pat * 211), "R3/R4/R5/R6 sign pattern", tries);
    drain();
    rand_p(1500);
    for (int pat = 0; pat < 16; pat++) send(qpsk(15 - pat, 1024), "R3/R5/R6 second matrix", tries);
    drain();

    rand_p(2048);
    for (int r = 0; r < NR; r++) pm[r][1] = 0;
    for (int pat = 0; pat < 8; pat++) send(qpsk(pat, 700), "R5 zero-norm column", tries);
    drain();

    rand_p(4000);
    for (int r = 0; r < NR; r++) pm[r][0] = (r % 2 == 0) ? 16'sd1 : -16'sd1;
    for (int pat = 0; pat < 16; pat++) send(qpsk(pat, 2000), "R5 quotient clamp", tries);
    drain();

    rand_p(30000);
    for (int pat = 0; pat < 16; pat++) send(qpsk(pat, 8000), "R4/R6 saturation", tries);
    drain();

    rand_p(2048);
    fork
      begin
        for (int k = 0; k < 12; k++) begin
          send(qpsk(k, 400 + 97 * k), "R8 burst", tries);
          chk(tries == 1, $sformatf("R8 burst vector %0d took %0d tries expected 1", k, tries));
        end
      end
      begin
        do @(negedge clk); while (!m_tvalid);
        run = 0;
        while (m_tvalid) begin run++; @(negedge clk); end
      end
    join
    chk(run == 12, $sformatf("R8 consecutive outputs %0d expected 12", run));
    drain();

    rand_p(2048);
    bp_mode = 1'b1;
    for (int k = 0; k < 60; k++)
      send(qpsk(int'($urandom_range(15)), int'($urandom_range(4000, 200))), "R10 backpressure", tries);
    drain();
    bp_mode = 1'b0;
    repeat (20) @(negedge clk);
    chk(expq.size() == 0 && m_tvalid === 1'b0,
        $sformatf("R10 pending %0d valid %b expected 0 0", expq.size(), m_tvalid));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule